// File: doc/BRIEF.md
# Serial GPIO shift controller

This block extends a chip's general-purpose I/O through a daisy chain of external shift registers. It handles up to 32 remote ports, and each port carries between one and four bits. Software programs the block through a small register interface. Each port has a word that sets the level driven on each of its output bits. A mask chooses which ports take part in a scan. Further registers set the number of bits per port, continuous rescanning and the serial clock divisor.

During a scan the block drives a serial clock. It shifts one output bit per serial period onto a data line and samples one input bit per period from a return line. When the chain has been walked, a load strobe runs for one serial period so that the external parts latch their outputs and capture their inputs. The sampled bits then enter the input data words together, in a single cycle. A scan starts from a software write, or it repeats continuously when auto-repeat is on.

Top module: `sgpio_ctrl`

## Requirements
- R1: After reset the following hold: every port word reads 0, the enable mask reads 0xFFFFFFFF, the control word reads 0, the divisor reads 10, the serial clock is high and the load strobe is low. Whenever no scan runs, the serial clock stays high and the load strobe stays low.
- R2: The chain order is bit index in the outer loop (0 up to width-1) and port number in the inner loop (0 up to 31, ascending). Only ports whose bit is set in the enable mask (address 0x24) shift. Width is 1 plus the field in control bits [1:0] (address 0x25). Width and mask are captured when a scan begins.
- R3: The output level of bit n of port p is set by the 3-bit code in bits 3n+2..3n of port word p (address p, 0x00..0x1F). Code 1 drives high and every other code drives low. The data line changes only on a falling edge of the serial clock.
- R4: The return line is sampled on the rising edge of the serial clock. The bit of port p at index b lands in bit p of input word b (address 0x20+b).
- R5: The input words change only at the end of the load strobe, with all bits updated in the same cycle. Bits that were not part of the scan keep their old values, and reads taken during a scan return the previous contents.
- R6: Every scan ends with the load strobe high for exactly one serial period, and the serial clock stays high while the strobe is high.
- R7: One serial period is D system cycles, where D is the value in divisor bits [11:0] (address 0x26). A value of 0 or 1 acts as 2.
- R8: Writing the control word with bit 3 set while idle starts one scan. Control bit 4 reads 1 until that scan's load strobe ends. Start writes made while busy are ignored.
- R9: When control bit 2 (auto-repeat) is set, the block rescans continuously without any start write and stays busy.
- R10: The input words are read-only, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 6 | Register read address (combinational read) |
| rd_data | output | 32 | Register read data |
| sclk | output | 1 | Serial clock to the chain |
| sdout | output | 1 | Serial output data |
| sload | output | 1 | Load strobe, one serial period per scan |
| sdin | input | 1 | Serial input data from the chain |

## Verification
Two things can coincide: software reading an input word, and the scan committing its sampled bits, which happens in the cycle the load strobe drops. The bench fixes the read address on input word 0 for a whole scan and samples the read data every cycle. Every sample taken while the strobe is high or before it must equal the old word. The first sample taken after the strobe falls must equal the full new word, with no mix of old and new bits. A start write issued in the middle of a busy scan is also checked: the bench counts the load pulses that follow and expects exactly one.

// File: rtl/sgpio_pkg.sv
package sgpio_pkg;
    localparam int SRC_W  = 3;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] ADR_INDATA = 6'h20;
    localparam logic [ADDR_W-1:0] ADR_ENABLE = 6'h24;
    localparam logic [ADDR_W-1:0] ADR_CTRL   = 6'h25;
    localparam logic [ADDR_W-1:0] ADR_DIV    = 6'h26;

    localparam int CTRL_AUTO  = 2;
    localparam int CTRL_START = 3;
    localparam int CTRL_BUSY  = 4;

    localparam logic [SRC_W-1:0] SRC_HIGH = 3'd1;

    typedef enum logic [1:0] {
        SCAN_IDLE,
        SCAN_SHIFT,
        SCAN_LOAD
    } scan_state_e;

    typedef struct packed {
        logic       auto_rep;
        logic [1:0] width_m1;
    } scan_mode_t;

    function automatic logic src_to_level(input logic [SRC_W-1:0] code);
        return code == SRC_HIGH;
    endfunction
endpackage

// File: rtl/sgpio_clkdiv.sv
module sgpio_clkdiv #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             fall_tick,
    output logic             rise_tick
);
    localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] eff;
    logic [DIV_W-1:0] half;

    always_comb begin
        eff  = (div < MIN_DIV) ? MIN_DIV : div;
        half = eff >> 1;
    end

    assign fall_tick = run && (cnt == '0);
    assign rise_tick = run && (cnt == half);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt >= eff - 1'b1) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // A serial period never shrinks below two system cycles
    assert_min_period_R7: assert property (@(posedge clk) disable iff (rst)
        fall_tick |=> !fall_tick);
endmodule

// File: rtl/sgpio_regs.sv
module sgpio_regs
    import sgpio_pkg::*;
#(
    parameter int NPORTS  = 32,
    parameter int MAXB    = 4,
    parameter int DIV_W   = 12,
    parameter int DIV_RST = 10,
    localparam int CFG_W  = MAXB * SRC_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic [ADDR_W-1:0]              rd_addr,
    output logic [DATA_W-1:0]              rd_data,
    output logic [NPORTS-1:0][CFG_W-1:0]   port_cfg,
    output logic [NPORTS-1:0]              port_en,
    output scan_mode_t                     mode,
    output logic [DIV_W-1:0]               div,
    output logic                           start_req,
    input  logic                           busy,
    input  logic [MAXB-1:0][NPORTS-1:0]    in_words
);
    localparam int PIDX_W = $clog2(NPORTS);
    localparam logic [ADDR_W-1:0] NP_A   = ADDR_W'(NPORTS);
    localparam logic [ADDR_W-1:0] IN_END = ADR_INDATA + ADDR_W'(MAXB);

    always_ff @(posedge clk) begin
        if (rst) begin
            port_cfg <= '0;
            port_en  <= '1;
            mode     <= '0;
            div      <= DIV_W'(DIV_RST);
        end else if (wr_en) begin
            if (wr_addr < NP_A) begin
                port_cfg[wr_addr[PIDX_W-1:0]] <= wr_data[CFG_W-1:0];
            end else if (wr_addr == ADR_ENABLE) begin
                port_en <= wr_data[NPORTS-1:0];
            end else if (wr_addr == ADR_CTRL) begin
                mode.width_m1 <= wr_data[1:0];
                mode.auto_rep <= wr_data[CTRL_AUTO];
            end else if (wr_addr == ADR_DIV) begin
                div <= wr_data[DIV_W-1:0];
            end
        end
    end

    assign start_req = wr_en && (wr_addr == ADR_CTRL) && wr_data[CTRL_START];

    always_comb begin
        rd_data = '0;
        if (rd_addr < NP_A) begin
            rd_data[CFG_W-1:0] = port_cfg[rd_addr[PIDX_W-1:0]];
        end else if (rd_addr >= ADR_INDATA && rd_addr < IN_END) begin
            rd_data[NPORTS-1:0] = in_words[rd_addr[1:0]];
        end else if (rd_addr == ADR_ENABLE) begin
            rd_data[NPORTS-1:0] = port_en;
        end else if (rd_addr == ADR_CTRL) begin
            rd_data[1:0]         = mode.width_m1;
            rd_data[CTRL_AUTO]   = mode.auto_rep;
            rd_data[CTRL_BUSY]   = busy;
        end else if (rd_addr == ADR_DIV) begin
            rd_data[DIV_W-1:0] = div;
        end
    end
endmodule

// File: rtl/sgpio_scan.sv
module sgpio_scan
    import sgpio_pkg::*;
#(
    parameter int NPORTS = 32,
    parameter int MAXB   = 4,
    localparam int CFG_W = MAXB * SRC_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start_req,
    input  logic [NPORTS-1:0][CFG_W-1:0] port_cfg,
    input  logic [NPORTS-1:0]            port_en,
    input  scan_mode_t                   mode,
    input  logic                         fall_tick,
    input  logic                         rise_tick,
    input  logic                         sdin,
    output logic                         run,
    output logic                         busy,
    output logic                         sclk,
    output logic                         sdout,
    output logic                         sload,
    output logic [MAXB-1:0][NPORTS-1:0]  in_words
);
    localparam int PIDX_W = $clog2(NPORTS);
    localparam logic [PIDX_W-1:0] LAST_P = PIDX_W'(NPORTS - 1);

    scan_state_e                 state;
    logic [1:0]                  bidx;
    logic [PIDX_W-1:0]           pidx;
    logic [NPORTS-1:0]           en_snap;
    logic [1:0]                  wm1_snap;
    logic                        got_fall;
    logic [MAXB-1:0][NPORTS-1:0] shadow;

    logic             slot_en;
    logic             last_slot;
    logic [SRC_W-1:0] cur_code;
    logic             step;
    logic             launch;
    logic             commit;
    logic             begin_scan;

    always_comb begin
        slot_en    = en_snap[pidx];
        last_slot  = (pidx == LAST_P) && (bidx == wm1_snap);
        cur_code   = port_cfg[pidx][int'(bidx)*SRC_W +: SRC_W];
        step       = (state == SCAN_SHIFT) && (got_fall ? rise_tick : !slot_en);
        launch     = (state == SCAN_SHIFT) && !got_fall && slot_en && fall_tick;
        commit     = (state == SCAN_LOAD) && sload && fall_tick;
        begin_scan = ((state == SCAN_IDLE) && (start_req || mode.auto_rep))
                   || (commit && mode.auto_rep);
    end

    assign busy = (state != SCAN_IDLE);
    assign run  = busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SCAN_IDLE;
            bidx     <= '0;
            pidx     <= '0;
            en_snap  <= '0;
            wm1_snap <= '0;
            got_fall <= 1'b0;
            shadow   <= '0;
            in_words <= '0;
            sclk     <= 1'b1;
            sdout    <= 1'b0;
            sload    <= 1'b0;
        end else begin
            // Sequencer: walk bit index outer, port inner
            if (begin_scan) begin
                state    <= SCAN_SHIFT;
                bidx     <= '0;
                pidx     <= '0;
                en_snap  <= port_en;
                wm1_snap <= mode.width_m1;
                got_fall <= 1'b0;
            end else if (commit) begin
                state <= SCAN_IDLE;
            end else if (step) begin
                if (last_slot) begin
                    state <= SCAN_LOAD;
                end else if (pidx == LAST_P) begin
                    pidx <= '0;
                    bidx <= bidx + 1'b1;
                end else begin
                    pidx <= pidx + 1'b1;
                end
            end

            // Falling serial edge: present the next output bit
            if (launch) begin
                sclk     <= 1'b0;
                sdout    <= src_to_level(cur_code);
                got_fall <= 1'b1;
            end

            // Rising serial edge: sample the return line
            if (step && got_fall) begin
                sclk                <= 1'b1;
                shadow[bidx][pidx]  <= sdin;
                got_fall            <= 1'b0;
            end

            // Load strobe spans one full serial period
            if (state == SCAN_LOAD && fall_tick) begin
                sload <= !sload;
            end

            if (commit) begin
                in_words <= shadow;
            end
            if (state == SCAN_IDLE && begin_scan) begin
                shadow <= in_words;
            end
        end
    end

    assert_load_clk_high_R6: assert property (@(posedge clk) disable iff (rst)
        sload |-> sclk);

    assert_inputs_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(in_words));

    assert_busy_ends_after_load_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(sload));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sclk && !sload));

    assert_shift_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk) |-> $past(fall_tick));
endmodule

// File: rtl/sgpio_ctrl.sv
module sgpio_ctrl
    import sgpio_pkg::*;
#(
    parameter int NPORTS  = 32,
    parameter int MAXB    = 4,
    parameter int DIV_W   = 12,
    parameter int DIV_RST = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              sclk,
    output logic              sdout,
    output logic              sload,
    input  logic              sdin
);
    localparam int CFG_W = MAXB * SRC_W;

    logic [NPORTS-1:0][CFG_W-1:0] port_cfg;
    logic [NPORTS-1:0]            port_en;
    scan_mode_t                   mode;
    logic [DIV_W-1:0]             div;
    logic                         start_req;
    logic                         busy;
    logic                         run;
    logic                         fall_tick;
    logic                         rise_tick;
    logic [MAXB-1:0][NPORTS-1:0]  in_words;

    sgpio_regs #(
        .NPORTS (NPORTS),
        .MAXB   (MAXB),
        .DIV_W  (DIV_W),
        .DIV_RST(DIV_RST)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .port_cfg (port_cfg),
        .port_en  (port_en),
        .mode     (mode),
        .div      (div),
        .start_req(start_req),
        .busy     (busy),
        .in_words (in_words)
    );

    sgpio_clkdiv #(
        .DIV_W(DIV_W)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .div      (div),
        .fall_tick(fall_tick),
        .rise_tick(rise_tick)
    );

    sgpio_scan #(
        .NPORTS(NPORTS),
        .MAXB  (MAXB)
    ) u_scan (
        .clk      (clk),
        .rst      (rst),
        .start_req(start_req),
        .port_cfg (port_cfg),
        .port_en  (port_en),
        .mode     (mode),
        .fall_tick(fall_tick),
        .rise_tick(rise_tick),
        .sdin     (sdin),
        .run      (run),
        .busy     (busy),
        .sclk     (sclk),
        .sdout    (sdout),
        .sload    (sload),
        .in_words (in_words)
    );
endmodule

// File: tb/tb_sgpio_ctrl.sv
module tb_sgpio_ctrl;
    import sgpio_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        sclk;
    logic        sdout;
    logic        sload;
    logic        sdin = 1'b0;

    always #4 clk = ~clk;

    sgpio_ctrl dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .sclk(sclk), .sdout(sdout),
        .sload(sload), .sdin(sdin)
    );

    typedef struct {
        logic out_bit;
        logic in_bit;
    } item_t;

    item_t       exp_q[$];
    int          n_chk = 0;
    int          n_fail = 0;
    logic [11:0] cfg_m[32];
    logic [31:0] in_pat[4];
    logic [31:0] in_exp[4];

    int   sload_cnt = 0;
    int   sload_len = 0;
    int   last_sload_len = 0;
    logic load_clk_bad = 1'b0;
    logic prev_sclk = 1'b1;
    logic prev_sload = 1'b0;
    logic pend_out = 1'b0;
    logic pend_valid = 1'b0;

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // Monitor: models the external chain and scores the shifted bits
    always @(negedge clk) begin
        item_t it;
        if (!rst) begin
            if (prev_sclk && !sclk) begin
                if (exp_q.size() == 0) begin
                    check("R2 unexpected extra serial bit", 32'd1, 32'd0);
                end else begin
                    it = exp_q.pop_front();
                    sdin = it.in_bit;
                    pend_out = it.out_bit;
                    pend_valid = 1'b1;
                end
            end
            if (!prev_sclk && sclk && pend_valid) begin
                check("R3 sdout level at rising sclk", {31'b0, sdout}, {31'b0, pend_out});
                pend_valid = 1'b0;
            end
            if (sload) begin
                sload_len++;
                if (!sclk) load_clk_bad = 1'b1;
            end
            if (prev_sload && !sload) begin
                sload_cnt++;
                last_sload_len = sload_len;
                sload_len = 0;
            end
        end
        prev_sclk = sclk;
        prev_sload = sload;
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic set_cfg(input int p, input logic [11:0] v);
        wr(6'(p), {20'b0, v});
        cfg_m[p] = v;
    endtask

    // Driver: pushes the expected chain items for one scan
    task automatic push_scan(input int w, input logic [31:0] en);
        item_t it;
        for (int b = 0; b < w; b++) begin
            for (int p = 0; p < 32; p++) begin
                if (en[p]) begin
                    it.out_bit = (cfg_m[p][3*b +: 3] == 3'd1);
                    it.in_bit  = in_pat[b][p];
                    exp_q.push_back(it);
                    in_exp[b][p] = in_pat[b][p];
                end
            end
        end
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        int guard;
        guard = 0;
        d = 32'h10;
        while (d[CTRL_BUSY] && guard < 20000) begin
            rd(ADR_CTRL, d);
            guard++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] old0;
        logic        stale_bad;
        logic        seen_end;
        logic        ps;
        int          s0;
        int          k;

        for (int p = 0; p < 32; p++) cfg_m[p] = '0;
        for (int b = 0; b < 4; b++) begin in_exp[b] = '0; in_pat[b] = '0; end

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(ADR_CTRL, d);   check("R1 control after reset", d, 32'h0);
        rd(ADR_ENABLE, d); check("R1 enable after reset", d, 32'hFFFF_FFFF);
        rd(ADR_DIV, d);    check("R1 divisor after reset", d, 32'd10);
        rd(6'd5, d);       check("R1 port word after reset", d, 32'h0);
        check("R1 sclk idle high", {31'b0, sclk}, 32'd1);
        check("R1 sload idle low", {31'b0, sload}, 32'd0);

        // Scan A: 1 bit per port, all ports, divisor 0 acts as 2
        wr(ADR_DIV, 32'd0);
        set_cfg(0, 12'h001);
        set_cfg(3, 12'h001);
        set_cfg(7, 12'h002);
        set_cfg(12, 12'h009);
        set_cfg(31, 12'h007);
        in_pat[0] = 32'hA5C3_0F96;
        push_scan(1, 32'hFFFF_FFFF);
        wr(ADR_CTRL, 32'h8);
        wait_idle();
        check("R7 divisor 0 gives 2-cycle load pulse", last_sload_len, 32'd2);
        check("R2 all 32 bits shifted", exp_q.size(), 32'd0);
        rd(ADR_INDATA, d);      check("R4 input word 0 after scan", d, in_exp[0]);
        rd(ADR_INDATA + 6'd1, d); check("R5 word 1 untouched by 1-bit scan", d, 32'h0);

        // Scan B: 4 bits per port, ports 0, 2, 31, divisor 3
        wr(ADR_ENABLE, 32'h8000_0005);
        wr(ADR_CTRL, 32'h3);
        wr(ADR_DIV, 32'd3);
        set_cfg(2, {3'd1, 3'd0, 3'd1, 3'd4});
        set_cfg(31, {3'd0, 3'd1, 3'd1, 3'd1});
        in_pat[0] = 32'hFFFF_FFFF;
        in_pat[1] = 32'hFFFF_FFFF;
        in_pat[2] = 32'h8000_0001;
        in_pat[3] = 32'h0000_0004;
        old0 = in_exp[0];
        push_scan(4, 32'h8000_0005);
        s0 = sload_cnt;
        wr(ADR_CTRL, 32'hB);

        // Clash: hold a read on input word 0 across the commit cycle
        rd_addr = ADR_INDATA;
        stale_bad = 1'b0;
        seen_end = 1'b0;
        ps = 1'b0;
        k = 0;
        while (!seen_end && k < 5000) begin
            @(negedge clk);
            if (k == 20) begin
                wr_en = 1'b1; wr_addr = ADR_CTRL; wr_data = 32'hB;
            end else begin
                wr_en = 1'b0;
            end
            #1;
            if (ps && !sload) begin
                check("R5 full new word visible once load ends", rd_data, in_exp[0]);
                seen_end = 1'b1;
            end else if (rd_data !== old0) begin
                stale_bad = 1'b1;
            end
            ps = sload;
            k++;
        end
        wr_en = 1'b0;
        check("R5 reads during scan return old word", {31'b0, stale_bad}, 32'd0);
        check("R2 ordered bits of enabled ports only", exp_q.size(), 32'd0);
        for (int b = 1; b < 4; b++) begin
            rd(ADR_INDATA + 6'(b), d);
            check("R4 input word per bit index", d, in_exp[b]);
        end
        check("R6 load pulse lasts one serial period", last_sload_len, 32'd3);
        check("R6 sclk high during load", {31'b0, load_clk_bad}, 32'd0);
        repeat (40) @(negedge clk);
        check("R8 start while busy ignored", sload_cnt, s0 + 1);
        rd(ADR_CTRL, d);
        check("R8 busy clear after scan", {31'b0, d[CTRL_BUSY]}, 32'd0);

        // R10 input words are read-only
        wr(ADR_INDATA + 6'd1, 32'h0);
        rd(ADR_INDATA + 6'd1, d);
        check("R10 write to input word ignored", d, in_exp[1]);

        // Scan C: auto-repeat, port 0 only, 1 bit
        wr(ADR_ENABLE, 32'h1);
        in_pat[0] = 32'h0;
        for (int n = 0; n < 8; n++) push_scan(1, 32'h1);
        s0 = sload_cnt;
        wr(ADR_CTRL, 32'h4);
        k = 0;
        while (sload_cnt < s0 + 3 && k < 5000) begin
            @(negedge clk);
            k++;
        end
        check("R9 auto-repeat rescans without start", {31'b0, sload_cnt >= s0 + 3}, 32'd1);
        rd(ADR_CTRL, d);
        check("R9 busy stays set under auto-repeat", {31'b0, d[CTRL_BUSY]}, 32'd1);
        wr(ADR_CTRL, 32'h0);
        wait_idle();
        rd(ADR_CTRL, d);
        check("R9 stops after auto-repeat cleared", {31'b0, d[CTRL_BUSY]}, 32'd0);
        exp_q.delete();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule